// File: doc/BRIEF.md
# Completion Poll Sequencer for a Memory-Card Host Controller

This block decides when a bus transaction issued by a memory-card host controller has really finished. A driver-side front end names the kind of transaction it has just launched and pulses a start strobe. The block then watches the flag byte of a sampled controller status word. A second sampled status word is also watched for one kind of transaction. The block walks a short wait sequence that depends on the transaction kind. Each stage of the sequence waits on its own completion condition. Two error flags are checked in every stage.

Each stage has a cycle limit taken from an input. When the sequence ends, the block gives a one-cycle completion pulse and a result code. The result code tells the caller whether the transaction completed cleanly, failed on a card error, ran out of time, or named a kind the block does not know. The front end only has to launch the transaction, pulse start and wait for the pulse.

Top module: `poll_seq`

## Requirements
- R1: Flags are bits [31:24] of `stat_a` and `stat_b`, written below as byte masks. Kind 0 (register write) completes when `stat_a` flag 0x10 (bit 28) is set.
- R2: Kind 1 (command write) first waits for `stat_a` flag 0x20 (bit 29), then for flag 0x10. Flag 0x10 alone never satisfies the first stage.
- R3: Kind 2 (interrupt fetch) completes only when `stat_a` flags 0x40 (bit 30) and 0x10 are both set. Either one alone does not complete it.
- R4: Kind 3 (long data read) first waits for `stat_a` flag 0x40, then for `stat_b` flag 0x20 (bit 29) to be clear.
- R5: In any wait stage, a set `stat_a` flag 0x01 or 0x02 (bits 24/25) ends the sequence with result 1 (card error). This check wins over a completion condition met in the same cycle.
- R6: Each stage evaluates at most `tmo_lim` cycles (a value of 0 counts as 1). If its condition is not met, the sequence ends with result 2 (timeout). The count restarts at every new stage.
- R7: A start with a kind code of 4 to 7 ends at once with result 3 (unknown kind). `done` and `err` appear in the cycle after the start.
- R8: `done` is a one-cycle pulse on every completion. `err` pulses with it only when the result is not 0 (result 0 = success). `result` is cleared by an accepted start and otherwise holds the last completion's code.
- R9: A start strobe while `busy` is high is ignored, including the kind code that comes with it.
- R10: After reset, `busy`, `done`, `err` and `result` are 0. `busy` is high from the cycle after an accepted known-kind start until the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a wait sequence |
| kind | input | 3 | Transaction kind code |
| stat_a | input | 32 | Sampled primary status word |
| stat_b | input | 32 | Sampled secondary status word |
| tmo_lim | input | TW | Per-stage cycle limit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Error pulse, only together with done |
| result | output | 2 | 0 ok, 1 card error, 2 timeout, 3 unknown kind |

## Verification
The hardest cases to reach are those where the cause of completion is the stage boundary in a two-stage sequence. One case is a timeout in the second stage, which shows that the stage counter restarts. Another is a card error that appears only after the first stage has passed. The directed tests reach both by changing the status words at a chosen clock edge in the middle of a sequence. They then check that completion lands on the exact cycle computed from the per-stage limit. A start pulse with an unknown kind is also sent during a pending wait. This shows that the block neither aborts nor re-latches the kind.

// File: rtl/poll_seq.sv
module poll_seq #(
  parameter int TW = 16,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    kind,
  input  logic [SW-1:0] stat_a,
  input  logic [SW-1:0] stat_b,
  input  logic [TW-1:0] tmo_lim,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    result
);
  localparam int FL = SW - 8;
  localparam logic [1:0] K_REG = 2'd0, K_CMD = 2'd1, K_INT = 2'd2, K_RD = 2'd3;
  localparam logic [1:0] RS_OK = 2'd0, RS_CARD = 2'd1, RS_TMO = 2'd2, RS_KIND = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_ONE, S_TWO} st_t;

  st_t           st;
  logic [1:0]    kind_q;
  logic [TW-1:0] cnt;
  logic          met, last, expire;

  wire [7:0] fa = stat_a[SW-1:FL];
  wire [7:0] fb = stat_b[SW-1:FL];
  wire hit_err = |fa[1:0];

  assign busy = (st != S_IDLE);
  assign last = (st == S_TWO) || (kind_q == K_REG) || (kind_q == K_INT);
  assign expire = ({1'b0, cnt} + 1'b1) >= {1'b0, tmo_lim};

  always_comb begin
    case (kind_q)
      K_REG:   met = fa[4];
      K_CMD:   met = (st == S_ONE) ? fa[5] : fa[4];
      K_INT:   met = fa[6] & fa[4];
      default: met = (st == S_ONE) ? fa[6] : !fb[5];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind_q <= K_REG;
      cnt    <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      result <= RS_OK;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          result <= RS_OK;
          if (!kind[2]) begin
            kind_q <= kind[1:0];
            st     <= S_ONE;
            cnt    <= '0;
          end else begin
            done   <= 1'b1;
            err    <= 1'b1;
            result <= RS_KIND;
          end
        end
      end else if (hit_err) begin
        st <= S_IDLE; done <= 1'b1; err <= 1'b1; result <= RS_CARD;
      end else if (met) begin
        if (last) begin
          st <= S_IDLE; done <= 1'b1; result <= RS_OK;
        end else begin
          st  <= S_TWO;
          cnt <= '0;
        end
      end else if (expire) begin
        st <= S_IDLE; done <= 1'b1; err <= 1'b1; result <= RS_TMO;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  p_clean_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (result == RS_OK));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(kind_q));
  p_fall_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_bad_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && kind[2]) |=> (done && err && result == RS_KIND));
  p_card_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hit_err) |=> (done && err && result == RS_CARD));
  p_tmo_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RS_TMO) |-> $past(busy));
endmodule

// File: tb/poll_seq_tb.sv
module poll_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  kind = '0;
  logic [31:0] stat_a = '0;
  logic [31:0] stat_b = '0;
  logic [15:0] tmo_lim = 16'd8;
  logic        busy, done, err;
  logic [1:0]  result;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  poll_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
    .stat_a(stat_a), .stat_b(stat_b), .tmo_lim(tmo_lim),
    .busy(busy), .done(done), .err(err), .result(result)
  );

  localparam int NV = 13;
  // kind[26:24] a_flags[23:16] b_flags[15:8] result[7:6] latency[5:0]
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 8'h10, 8'h00, 2'd0, 6'd1},  // R1
    {3'd0, 8'h20, 8'h00, 2'd2, 6'd8},  // R1
    {3'd1, 8'h30, 8'h00, 2'd0, 6'd2},  // R2
    {3'd1, 8'h10, 8'h00, 2'd2, 6'd8},  // R2
    {3'd2, 8'h50, 8'h00, 2'd0, 6'd1},  // R3
    {3'd2, 8'h40, 8'h00, 2'd2, 6'd8},  // R3
    {3'd2, 8'h10, 8'h00, 2'd2, 6'd8},  // R3
    {3'd3, 8'h40, 8'h00, 2'd0, 6'd2},  // R4
    {3'd3, 8'h40, 8'h20, 2'd2, 6'd9},  // R4 R6
    {3'd0, 8'h11, 8'h00, 2'd1, 6'd1},  // R5
    {3'd1, 8'h02, 8'h00, 2'd1, 6'd1},  // R5
    {3'd5, 8'h00, 8'h00, 2'd3, 6'd0},  // R7
    {3'd7, 8'h10, 8'h00, 2'd3, 6'd0}   // R7
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go(input logic [2:0] k, input logic [7:0] a, input logic [7:0] b,
                    output int lat);
    @(negedge clk);
    kind = k; stat_a = {a, 24'h0}; stat_b = {b, 24'h0}; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !err && result == 2'd0, "R10 reset", {busy, done, err, result}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      go(VEC[i][26:24], VEC[i][23:16], VEC[i][15:8], lat);
      chk(lat == int'(VEC[i][5:0]), $sformatf("R6 vec%0d latency", i), lat, VEC[i][5:0]);
      chk(result == VEC[i][7:6], $sformatf("R8 vec%0d result", i), result, VEC[i][7:6]);
      chk(err == (VEC[i][7:6] != 2'd0), $sformatf("R8 vec%0d err", i), err, VEC[i][7:6] != 2'd0);
      @(negedge clk);
      chk(!done && !err && !busy, $sformatf("R8 vec%0d pulse", i), {done, err, busy}, 0);
    end

    // R8: result held after completion
    repeat (3) @(negedge clk);
    chk(result == 2'd3, "R8 hold", result, 3);

    // R10: busy after accepted start, result cleared
    @(negedge clk);
    kind = 3'd0; stat_a = '0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy && result == 2'd0, "R10 busy", {busy, result}, 4);
    // R9: start with unknown kind during wait ignored
    @(negedge clk);
    kind = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R9 ignored", {busy, done}, 2);
    stat_a = 32'h1000_0000;
    @(posedge clk);
    @(negedge clk);
    chk(done && result == 2'd0, "R9 completes ok", {done, result}, 4);

    // R6: counter restarts for the second stage of a command write
    @(negedge clk);
    kind = 3'd1; stat_a = '0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    stat_a = 32'h2000_0000;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(!done && busy, "R6 stage two still waiting", {done, busy}, 1);
    @(posedge clk);
    @(negedge clk);
    chk(done && result == 2'd2, "R6 stage two timeout", result, 2);

    // R5: card error raised during second stage of a long read
    go(3'd3, 8'h40, 8'h20, lat);
    chk(lat == 9, "R4 stage two hold", lat, 9);
    @(negedge clk);
    kind = 3'd3; stat_a = 32'h4000_0000; stat_b = 32'h2000_0000; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    stat_a = 32'h4100_0000;
    @(posedge clk);
    @(negedge clk);
    chk(done && err && result == 2'd1, "R5 stage two error", result, 1);

    // R6: limit of zero and one behave as a single evaluation
    tmo_lim = 16'd0;
    go(3'd0, 8'h00, 8'h00, lat);
    chk(lat == 1 && result == 2'd2, "R6 limit zero", lat, 1);
    tmo_lim = 16'd1;
    go(3'd2, 8'h40, 8'h00, lat);
    chk(lat == 1 && result == 2'd2, "R6 limit one", lat, 1);

    // R2: flag 0x20 arriving late passes stage one then 0x10 completes
    tmo_lim = 16'd8;
    @(negedge clk);
    kind = 3'd1; stat_a = 32'h1000_0000; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(busy && !done, "R2 needs 0x20 first", {busy, done}, 2);
    stat_a = 32'h3000_0000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(done && result == 2'd0, "R2 ordered ok", result, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule